// File: doc/BRIEF.md
# Accumulator-Link Micro-Operation Unit

This unit carries out the register-only operate instructions of a 12-bit accumulator machine. Each such instruction word holds a set of independent enable bits. Each bit names one small action on the 13-bit pair made of the link bit and the accumulator. The possible actions are clears, complements, an increment, and a rotate by one or two places. The unit receives the instruction word, the present accumulator and the present link. It returns the updated accumulator and link, and a flag that reports whether the word belonged to this instruction group.

All enabled actions in one word are applied in a fixed order: clears, then complements, then increment, then rotate. This makes combined encodings well defined. For example, a complement followed by an increment negates the accumulator. A carry out of the increment flips the link. When both rotate directions are requested, the word is treated as undefined and the pair is returned unchanged. A word from any other instruction group also leaves the pair unchanged and drops the flag.

The result is computed in one combinational path. A parameter places an output register after it, with synchronous active-high reset, or leaves it out.

Top module: `acclink_uop`

## Requirements
- R1: `g1_valid_o` is 1 exactly when instruction bits [11:9] are 3'b111 and bit [8] is 0. Octal 7000 to 7377 are the group words.
- R2: For any word outside the group, `ac_o` and `link_o` equal the `ac_i` and `link_i` that were presented with it.
- R3: Bit [7] clears the accumulator and bit [6] clears the link. Clears act before every other action.
- R4: Bit [5] complements the accumulator and bit [4] complements the link. Both act after the clears.
- R5: Bit [0] adds one to the accumulator after the complements. A carry out of bit 11 complements the link.
- R6: Bit [3] alone rotates the 13-bit pair {link, ac} right, after the increment. The link receives ac[0], and ac[11] receives the old link.
- R7: Bit [2] alone rotates the pair left. The link receives ac[11], and ac[0] receives the old link.
- R8: Bit [1] set together with exactly one rotate bit makes the rotate move two places. With no rotate bit set, bit [1] has no effect.
- R9: A group word with both bits [3] and [2] set returns the input pair unchanged, while `g1_valid_o` is still 1.
- R10: Octal 7041 returns the two's complement negation of the accumulator. Octal 7300 returns accumulator 0 and link 0.
- R11: While `rst` is high, the registered outputs read zero.
- R12: With REG_OUT = 1, the result for inputs present at one rising edge appears at the outputs after that edge. The outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 12 | Instruction word, bit 11 most significant |
| ac_i | input | 12 | Present accumulator |
| link_i | input | 1 | Present link bit |
| ac_o | output | 12 | Updated accumulator |
| link_o | output | 1 | Updated link bit |
| g1_valid_o | output | 1 | Word decoded as a group operate instruction |

## Verification
The unit holds no state beyond the output register. Any wrong decode or wrong step ordering therefore shows up on `ac_o` or `link_o` in the cycle right after the faulty word is applied. A swapped order of complement and increment, for example, shows up the first time both bits appear with a suitable accumulator value. Because of this, the bench sweeps every one of the 256 group encodings. Each encoding is run over accumulator values that expose carries, sign bits and wrap-around, with both link values. A mis-wired rotate neighbour or a lost carry-to-link shows up on the very next output sample.

// File: rtl/acclink_pkg.sv
package acclink_pkg;

  typedef struct packed {
    logic grp1;
    logic clr_ac;
    logic clr_lk;
    logic cmp_ac;
    logic cmp_lk;
    logic rot_r;
    logic rot_l;
    logic rot_dbl;
    logic inc;
  } uop_ctrl_t;

endpackage

// File: rtl/acclink_decode.sv
module acclink_decode
  import acclink_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] instr_i,
  output uop_ctrl_t         ctrl_o
);
  localparam int OPC_LO  = DATA_W - 3;
  localparam int GRP_BIT = DATA_W - 4;
  localparam int CLA_BIT = DATA_W - 5;
  localparam int CLL_BIT = DATA_W - 6;
  localparam int CMA_BIT = DATA_W - 7;
  localparam int CML_BIT = DATA_W - 8;
  localparam int RR_BIT  = DATA_W - 9;
  localparam int RL_BIT  = DATA_W - 10;
  localparam int DBL_BIT = DATA_W - 11;
  localparam int INC_BIT = DATA_W - 12;

  always_comb begin
    ctrl_o.grp1    = (instr_i[DATA_W-1:OPC_LO] == 3'b111) && !instr_i[GRP_BIT];
    ctrl_o.clr_ac  = instr_i[CLA_BIT];
    ctrl_o.clr_lk  = instr_i[CLL_BIT];
    ctrl_o.cmp_ac  = instr_i[CMA_BIT];
    ctrl_o.cmp_lk  = instr_i[CML_BIT];
    ctrl_o.rot_r   = instr_i[RR_BIT];
    ctrl_o.rot_l   = instr_i[RL_BIT];
    ctrl_o.rot_dbl = instr_i[DBL_BIT];
    ctrl_o.inc     = instr_i[INC_BIT];
  end
endmodule

// File: rtl/acclink_arith.sv
module acclink_arith
  import acclink_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  uop_ctrl_t         ctrl_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  output logic [DATA_W:0]   pair_o
);
  logic [DATA_W-1:0] ac_clr, ac_cmp, ac_inc;
  logic              lk_clr, lk_cmp, carry;

  always_comb begin
    ac_clr = ctrl_i.clr_ac ? '0 : ac_i;
    lk_clr = ctrl_i.clr_lk ? 1'b0 : link_i;
    ac_cmp = ctrl_i.cmp_ac ? ~ac_clr : ac_clr;
    lk_cmp = ctrl_i.cmp_lk ? ~lk_clr : lk_clr;
    {carry, ac_inc} = {1'b0, ac_cmp} + {{DATA_W{1'b0}}, ctrl_i.inc};
    pair_o = {lk_cmp ^ carry, ac_inc};
  end

  // R5
  always_comb begin
    carry_src_chk: assert (!carry || (ctrl_i.inc && (&ac_cmp)));
  end
endmodule

// File: rtl/acclink_rotate.sv
module acclink_rotate #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W:0] pair_i,
  input  logic            rot_r_i,
  input  logic            rot_l_i,
  input  logic            dbl_i,
  output logic [DATA_W:0] pair_o
);
  localparam int PW = DATA_W + 1;

  logic [DATA_W:0] r1, r2, l1, l2;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign r1[i] = pair_i[(i + 1) % PW];
    assign r2[i] = pair_i[(i + 2) % PW];
    assign l1[i] = pair_i[(i + PW - 1) % PW];
    assign l2[i] = pair_i[(i + PW - 2) % PW];
  end

  always_comb begin
    if (rot_r_i && !rot_l_i)      pair_o = dbl_i ? r2 : r1;
    else if (rot_l_i && !rot_r_i) pair_o = dbl_i ? l2 : l1;
    else                          pair_o = pair_i;
  end

  // R6
  always_comb begin
    rot_ones_chk: assert ($countones(pair_o) == $countones(pair_i));
  end
endmodule

// File: rtl/acclink_uop.sv
module acclink_uop
  import acclink_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              link_o,
  output logic              g1_valid_o
);
  uop_ctrl_t       ctrl;
  logic [DATA_W:0] arith_pair, rot_pair, next_pair;
  logic            keep;

  acclink_decode #(.DATA_W(DATA_W)) u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  acclink_arith #(.DATA_W(DATA_W)) u_arith (
    .ctrl_i (ctrl),
    .ac_i   (ac_i),
    .link_i (link_i),
    .pair_o (arith_pair)
  );

  acclink_rotate #(.DATA_W(DATA_W)) u_rot (
    .pair_i  (arith_pair),
    .rot_r_i (ctrl.rot_r),
    .rot_l_i (ctrl.rot_l),
    .dbl_i   (ctrl.rot_dbl),
    .pair_o  (rot_pair)
  );

  assign keep      = !ctrl.grp1 || (ctrl.rot_r && ctrl.rot_l);
  assign next_pair = keep ? {link_i, ac_i} : rot_pair;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        ac_o       <= '0;
        link_o     <= 1'b0;
        g1_valid_o <= 1'b0;
      end else begin
        ac_o       <= next_pair[DATA_W-1:0];
        link_o     <= next_pair[DATA_W];
        g1_valid_o <= ctrl.grp1;
      end
    end

    // R1
    valid_dec_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> g1_valid_o ==
        (($past(instr_i[DATA_W-1 -: 3]) == 3'b111) && !$past(instr_i[DATA_W-4])));

    // R2
    other_grp_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !g1_valid_o) |->
        (ac_o == $past(ac_i)) && (link_o == $past(link_i)));

    // R9
    both_rot_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && g1_valid_o && $past(instr_i[DATA_W-9]) && $past(instr_i[DATA_W-10]))
        |-> (ac_o == $past(ac_i)) && (link_o == $past(link_i)));

    // R10
    clear_both_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && g1_valid_o && $past(instr_i[DATA_W-5]) && $past(instr_i[DATA_W-6])
        && !$past(instr_i[DATA_W-7]) && !$past(instr_i[DATA_W-8])
        && ($past(instr_i[DATA_W-12 +: 4]) == 4'b0000))
        |-> (ac_o == '0) && !link_o);
  end else begin : g_comb
    always_comb begin
      ac_o       = next_pair[DATA_W-1:0];
      link_o     = next_pair[DATA_W];
      g1_valid_o = ctrl.grp1;
    end
  end
endmodule

// File: tb/acclink_uop_tb_top.sv
module acclink_uop_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] instr_i = '0;
  logic [11:0] ac_i = '0;
  logic        link_i = 1'b0;
  logic [11:0] ac_o;
  logic        link_o;
  logic        g1_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  acclink_uop #(.DATA_W(12), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .instr_i(instr_i), .ac_i(ac_i), .link_i(link_i),
    .ac_o(ac_o), .link_o(link_o), .g1_valid_o(g1_valid_o)
  );

  // {valid, link, ac}
  function automatic logic [13:0] model(logic [11:0] w, logic [11:0] a, logic l);
    logic [11:0] acc;
    logic        lk, c;
    int          steps;
    acc = a; lk = l;
    if (w[11:9] != 3'o7 || w[8]) return {1'b0, l, a};
    if (w[3] && w[2]) return {1'b1, l, a};
    if (w[7]) acc = 12'd0;
    if (w[6]) lk = 1'b0;
    if (w[5]) acc = ~acc;
    if (w[4]) lk = ~lk;
    if (w[0]) begin
      {c, acc} = {1'b0, acc} + 13'd1;
      if (c) lk = ~lk;
    end
    steps = w[1] ? 2 : 1;
    for (int s = 0; s < steps; s++) begin
      if (w[3])      {lk, acc} = {acc[0], lk, acc[11:1]};
      else if (w[2]) {lk, acc} = {acc[11], acc[10:0], lk};
    end
    return {1'b1, lk, acc};
  endfunction

  function automatic string tag_of(logic [11:0] w);
    if (w[3] && w[2]) return "R9";
    if (w[1] && (w[3] || w[2])) return "R8";
    if (w[3]) return "R6";
    if (w[2]) return "R7";
    if (w[0]) return "R5";
    if (w[5] || w[4]) return "R4";
    if (w[7] || w[6]) return "R3";
    return "R1";
  endfunction

  task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%b l=%b ac=%o, expected v=%b l=%b ac=%o",
               tag, act[13], act[12], act[11:0], exp[13], exp[12], exp[11:0]);
    end
  endtask

  task automatic run(logic [11:0] w, logic [11:0] a, logic l, string tag);
    @(negedge clk);
    instr_i = w; ac_i = a; link_i = l;
    @(negedge clk);
    check(tag, {g1_valid_o, link_o, ac_o}, model(w, a, l));
  endtask

  initial begin
    logic [11:0] samples [6];
    samples = '{12'o0000, 12'o7777, 12'o4000, 12'o0001, 12'o5134, 12'o3777};

    // R11: reset holds outputs at zero even with live inputs
    instr_i = 12'o7001; ac_i = 12'o0005; link_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", {g1_valid_o, link_o, ac_o}, 14'd0);
    rst = 1'b0;

    // R10: named encodings
    run(12'o7041, 12'o0005, 1'b0, "R10");
    check("R10", {g1_valid_o, link_o, ac_o}, {1'b1, 1'b0, 12'o7773});
    run(12'o7300, 12'o1234, 1'b1, "R10");
    check("R10", {g1_valid_o, link_o, ac_o}, {1'b1, 1'b0, 12'o0000});

    // R5: carry from increment flips link
    run(12'o7001, 12'o7777, 1'b0, "R5");
    check("R5", {g1_valid_o, link_o, ac_o}, {1'b1, 1'b1, 12'o0000});

    // R12: output holds until the next edge
    @(negedge clk);
    instr_i = 12'o7040; ac_i = 12'o0000; link_i = 1'b0;
    #2;
    check("R12", {g1_valid_o, link_o, ac_o}, {1'b1, 1'b1, 12'o0000});
    @(negedge clk);
    check("R12", {g1_valid_o, link_o, ac_o}, {1'b1, 1'b0, 12'o7777});

    // R2: other instruction groups leave the pair alone
    run(12'o7400, 12'o1111, 1'b1, "R2");
    run(12'o7501, 12'o2222, 1'b0, "R2");
    run(12'o6041, 12'o7777, 1'b1, "R2");
    run(12'o1377, 12'o0042, 1'b0, "R2");
    run(12'o0000, 12'o4000, 1'b1, "R2");

    // exhaustive sweep of group encodings
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 6; k++) begin
        for (int lv = 0; lv < 2; lv++) begin
          logic [11:0] w;
          w = 12'o7000 | 12'(e);
          run(w, samples[k], lv[0], tag_of(w));
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule